// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the arithmetic and flag unit of a small 8-bit processor. On each rising clock edge it takes an operation code and two operands. The register operand is the accumulator, an index register or the stack pointer, as picked upstream. The memory operand is a fetched byte or an immediate. The block also takes the current status byte. One edge later it presents the result, a write-back strobe and the new status byte. The register file and decimal-mode arithmetic live elsewhere. This unit works in plain binary.

Every operation is a single-cycle pass through one of three shared datapaths, so the block holds no sequencing state.
- A carry-propagate adder serves add, subtract, compare, increment and decrement.
- A shifter serves the two shifts and the two rotates.
- A bitwise unit serves AND, OR, XOR and the bit test.

The decode step then decides which flags each operation may touch and whether its result is written back. Some operations report through the status byte alone: compare, bit test and the flag-set or flag-clear operations. For these the write strobe is low and the result output keeps its last value.

The status byte is packed from bit 7 down to bit 0 as: negative N, overflow V, constant 1, break B, decimal D, interrupt disable I, zero Z, carry C.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted, and after it, until the first operation is captured: res_o is 0x00, res_wr_o is 0 and psr_o is 0x36 (I, B, Z and the constant bit set).
- R2: Opcode 0 (add) produces res = (reg + mem + C) mod 256 with write-back. C is set when the sum exceeds 255. V is set when both operands share a sign bit and the result's sign bit differs. Z and N follow the result.
- R3: Opcode 1 (subtract) produces res = (reg + (255 - mem) + C) mod 256 with write-back. C is an inverted borrow (1 = no borrow). V is set when reg and (255 - mem) share a sign bit and the result's sign bit differs. Z and N follow the result.
- R4: Opcode 11 (compare) does not write back. It sets C to reg >= mem and Z to reg == mem. It sets N to bit 7 of (reg - mem) mod 256. V is left unchanged.
- R5: Opcodes 2, 3 and 4 write back reg AND mem, reg OR mem and reg XOR mem respectively. Z and N follow the result; C and V are unchanged.
- R6: Opcodes 5 to 8 act on reg and write back the result. Opcode 5 shifts left and opcode 6 shifts right, each with a zero entering. Opcode 7 rotates left and opcode 8 rotates right, each through C. In every case the bit leaving the byte lands in C, and Z and N follow the result.
- R7: The following write back their result with Z and N updated and C and V unchanged: opcode 9 (increment reg mod 256), opcode 10 (decrement reg mod 256), opcode 13 (load mem) and opcode 14 (transfer reg).
- R8: Opcode 15 (stack-pointer transfer) writes back reg and leaves every status bit unchanged.
- R9: Opcode 12 (bit test) does not write back. It sets Z when (reg AND mem) is 0 and copies mem bit 7 into N and mem bit 6 into V.
- R10: Opcodes 16 to 22 do not write back and change only one flag each: 16 clears C, 17 sets C, 18 clears I, 19 sets I, 20 clears D, 21 sets D and 22 clears V.
- R11: Bit 5 of psr_o is always 1. B, D and I pass through from psr_i, except where R10 names them.
- R12: Opcodes 23 to 31 do not write back. They pass the status byte through unchanged, apart from the constant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| reg_i | input | 8 | Register operand (accumulator, index or stack pointer) |
| mem_i | input | 8 | Memory or immediate operand |
| psr_i | input | 8 | Current status byte (N V 1 B D I Z C) |
| res_o | output | 8 | Registered result |
| res_wr_o | output | 1 | Result should be written back to the destination register |
| psr_o | output | 8 | Registered updated status byte |

## Verification
Every result, write strobe and status byte is due exactly one rising edge after its operands are presented. There is no further latency for any operation.

The bench changes inputs just after a falling edge and compares the outputs at the next falling edge, which lies half a period after the capturing edge. That keeps each check in the cycle where its value is due.

Because the result register holds its value across non-writing operations, the bench model carries the last written result forward. This confirms that compare, bit test and the flag operations leave the result untouched.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DW = 8;

    // status byte bit positions
    localparam int FC   = 0;
    localparam int FZ   = 1;
    localparam int FI   = 2;
    localparam int FD   = 3;
    localparam int FB   = 4;
    localparam int FONE = 5;
    localparam int FV   = 6;
    localparam int FN   = 7;

    localparam logic [7:0] PSR_RST = 8'h36;

    typedef enum logic [4:0] {
        OP_ADC = 5'd0,  OP_SBC = 5'd1,  OP_AND = 5'd2,  OP_ORA = 5'd3,
        OP_EOR = 5'd4,  OP_ASL = 5'd5,  OP_LSR = 5'd6,  OP_ROL = 5'd7,
        OP_ROR = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_CMP = 5'd11,
        OP_BIT = 5'd12, OP_LDM = 5'd13, OP_XFR = 5'd14, OP_XSP = 5'd15,
        OP_CLC = 5'd16, OP_SEC = 5'd17, OP_CLI = 5'd18, OP_SEI = 5'd19,
        OP_CLD = 5'd20, OP_SED = 5'd21, OP_CLV = 5'd22
    } op_e;

    typedef enum logic [1:0] {SH_ASL, SH_LSR, SH_ROL, SH_ROR} shift_e;
    typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR} logic_e;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         ov
);
    logic [W:0] full;

    assign full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    assign sum  = full[W-1:0];
    assign co   = full[W];
    assign ov   = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    input  logic         ci,
    input  shift_e       mode,
    output logic [W-1:0] q,
    output logic         co
);
    always_comb begin
        unique case (mode)
            SH_ASL: begin q = {d[W-2:0], 1'b0}; co = d[W-1]; end
            SH_LSR: begin q = {1'b0, d[W-1:1]}; co = d[0];   end
            SH_ROL: begin q = {d[W-2:0], ci};   co = d[W-1]; end
            SH_ROR: begin q = {ci, d[W-1:1]};   co = d[0];   end
        endcase
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_e       sel,
    output logic [W-1:0] q
);
    always_comb begin
        case (sel)
            LG_OR:   q = a | b;
            LG_XOR:  q = a ^ b;
            default: q = a & b;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op_i,
    input  logic [W-1:0] reg_i,
    input  logic [W-1:0] mem_i,
    input  logic [7:0]   psr_i,
    output logic [W-1:0] res_o,
    output logic         res_wr_o,
    output logic [7:0]   psr_o
);
    localparam int SB = W - 1;
    localparam int VB = W - 2;

    op_e          op;
    logic [W-1:0] add_b, add_sum, sh_q, lg_q;
    logic         add_ci, add_co, add_ov, sh_co;
    shift_e       sh_sel;
    logic_e       lg_sel;

    logic [W-1:0] res_q, nxt_res;
    logic         wr_q, nxt_wr;
    logic [7:0]   psr_q, nxt_psr;
    logic         nz_upd;
    logic [W-1:0] nz_val;

    assign op = op_e'(op_i);

    // operand steering for the shared datapaths
    always_comb begin
        add_b  = mem_i;
        add_ci = psr_i[FC];
        case (op)
            OP_SBC:  add_b = ~mem_i;
            OP_CMP:  begin add_b = ~mem_i;       add_ci = 1'b1; end
            OP_INC:  begin add_b = '0;           add_ci = 1'b1; end
            OP_DEC:  begin add_b = '1;           add_ci = 1'b0; end
            default: ;
        endcase
        case (op)
            OP_LSR:  sh_sel = SH_LSR;
            OP_ROL:  sh_sel = SH_ROL;
            OP_ROR:  sh_sel = SH_ROR;
            default: sh_sel = SH_ASL;
        endcase
        case (op)
            OP_ORA:  lg_sel = LG_OR;
            OP_EOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    alu_adder #(.W(W)) u_add (
        .a(reg_i), .b(add_b), .ci(add_ci),
        .sum(add_sum), .co(add_co), .ov(add_ov)
    );

    alu_shifter #(.W(W)) u_sh (
        .d(reg_i), .ci(psr_i[FC]), .mode(sh_sel), .q(sh_q), .co(sh_co)
    );

    alu_bitwise #(.W(W)) u_lg (
        .a(reg_i), .b(mem_i), .sel(lg_sel), .q(lg_q)
    );

    // next-value decode
    always_comb begin
        nxt_res = res_q;
        nxt_wr  = 1'b0;
        nxt_psr = psr_i;
        nz_upd  = 1'b0;
        nz_val  = '0;
        case (op)
            OP_ADC, OP_SBC: begin
                nxt_res = add_sum; nxt_wr = 1'b1;
                nxt_psr[FC] = add_co; nxt_psr[FV] = add_ov;
                nz_upd = 1'b1; nz_val = add_sum;
            end
            OP_CMP: begin
                nxt_psr[FC] = add_co;
                nz_upd = 1'b1; nz_val = add_sum;
            end
            OP_INC, OP_DEC: begin
                nxt_res = add_sum; nxt_wr = 1'b1;
                nz_upd = 1'b1; nz_val = add_sum;
            end
            OP_AND, OP_ORA, OP_EOR: begin
                nxt_res = lg_q; nxt_wr = 1'b1;
                nz_upd = 1'b1; nz_val = lg_q;
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                nxt_res = sh_q; nxt_wr = 1'b1;
                nxt_psr[FC] = sh_co;
                nz_upd = 1'b1; nz_val = sh_q;
            end
            OP_BIT: begin
                nxt_psr[FZ] = (lg_q == '0);
                nxt_psr[FN] = mem_i[SB];
                nxt_psr[FV] = mem_i[VB];
            end
            OP_LDM: begin
                nxt_res = mem_i; nxt_wr = 1'b1;
                nz_upd = 1'b1; nz_val = mem_i;
            end
            OP_XFR: begin
                nxt_res = reg_i; nxt_wr = 1'b1;
                nz_upd = 1'b1; nz_val = reg_i;
            end
            OP_XSP: begin
                nxt_res = reg_i; nxt_wr = 1'b1;
            end
            OP_CLC:  nxt_psr[FC] = 1'b0;
            OP_SEC:  nxt_psr[FC] = 1'b1;
            OP_CLI:  nxt_psr[FI] = 1'b0;
            OP_SEI:  nxt_psr[FI] = 1'b1;
            OP_CLD:  nxt_psr[FD] = 1'b0;
            OP_SED:  nxt_psr[FD] = 1'b1;
            OP_CLV:  nxt_psr[FV] = 1'b0;
            default: ;
        endcase
        if (nz_upd) begin
            nxt_psr[FN] = nz_val[SB];
            nxt_psr[FZ] = (nz_val == '0);
        end
        nxt_psr[FONE] = 1'b1;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            wr_q  <= 1'b0;
            psr_q <= PSR_RST;
        end else begin
            res_q <= nxt_res;
            wr_q  <= nxt_wr;
            psr_q <= nxt_psr;
        end
    end

    assign res_o    = res_q;
    assign res_wr_o = wr_q;
    assign psr_o    = psr_q;

    // R4
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP) |=> (!res_wr_o && psr_o[FV] == $past(psr_i[FV])));

    // R8
    sp_flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_XSP) |=> (psr_o == ($past(psr_i) | 8'h20)));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_INC) |=> (res_o == W'($past(reg_i) + 1'b1)));

    // R10
    flag_op_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= OP_CLC && op_i <= OP_CLV) |=> (!res_wr_o && $stable(res_o)));

    // R11
    const_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psr_o[FONE]);
endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = 5'd23;
    logic [7:0] reg_i = '0, mem_i = '0, psr_i = '0;
    logic [7:0] res_o, psr_o;
    logic       res_wr_o;

    int checks = 0;
    int errors = 0;
    int prev_res = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .reg_i(reg_i), .mem_i(mem_i),
        .psr_i(psr_i), .res_o(res_o), .res_wr_o(res_wr_o), .psr_o(psr_o)
    );

    function automatic int setb(int v, int b, int x);
        return (v & ~(1 << b)) | ((x & 1) << b);
    endfunction

    function automatic int nz(int q, int res);
        int t;
        t = setb(q, 7, res >> 7);
        return setb(t, 1, (res == 0) ? 1 : 0);
    endfunction

    // expected {wr, res, psr}
    function automatic logic [16:0] model(int op, int r, int m, int p, int prev);
        int res, wr, q, s, c, nm;
        res = prev; wr = 0; q = p; c = p & 1; nm = 255 - m;
        case (op)
            0: begin s = r + m + c; res = s & 255; wr = 1;
                q = setb(q, 0, s > 255 ? 1 : 0);
                q = setb(q, 6, (((r ^ res) & (m ^ res) & 128) != 0) ? 1 : 0);
                q = nz(q, res); end
            1: begin s = r + nm + c; res = s & 255; wr = 1;
                q = setb(q, 0, s > 255 ? 1 : 0);
                q = setb(q, 6, (((r ^ res) & (nm ^ res) & 128) != 0) ? 1 : 0);
                q = nz(q, res); end
            2: begin res = r & m; wr = 1; q = nz(q, res); end
            3: begin res = r | m; wr = 1; q = nz(q, res); end
            4: begin res = r ^ m; wr = 1; q = nz(q, res); end
            5: begin res = (r << 1) & 255; wr = 1; q = setb(q, 0, r >> 7); q = nz(q, res); end
            6: begin res = r >> 1; wr = 1; q = setb(q, 0, r); q = nz(q, res); end
            7: begin res = ((r << 1) | c) & 255; wr = 1; q = setb(q, 0, r >> 7); q = nz(q, res); end
            8: begin res = (r >> 1) | (c << 7); wr = 1; q = setb(q, 0, r); q = nz(q, res); end
            9: begin res = (r + 1) & 255; wr = 1; q = nz(q, res); end
            10: begin res = (r + 255) & 255; wr = 1; q = nz(q, res); end
            11: begin
                q = setb(q, 0, (r >= m) ? 1 : 0);
                q = setb(q, 1, (r == m) ? 1 : 0);
                q = setb(q, 7, ((r - m) & 255) >> 7); end
            12: begin
                q = setb(q, 1, ((r & m) == 0) ? 1 : 0);
                q = setb(q, 7, m >> 7);
                q = setb(q, 6, m >> 6); end
            13: begin res = m; wr = 1; q = nz(q, res); end
            14: begin res = r; wr = 1; q = nz(q, res); end
            15: begin res = r; wr = 1; end
            16: q = setb(q, 0, 0);
            17: q = setb(q, 0, 1);
            18: q = setb(q, 2, 0);
            19: q = setb(q, 2, 1);
            20: q = setb(q, 3, 0);
            21: q = setb(q, 3, 1);
            22: q = setb(q, 6, 0);
            default: ;
        endcase
        q = q | 32;
        return {wr[0], res[7:0], q[7:0]};
    endfunction

    task automatic run(input int op, input int r, input int m, input int p, input string tag);
        logic [16:0] exp;
        op_i = op[4:0]; reg_i = r[7:0]; mem_i = m[7:0]; psr_i = p[7:0];
        exp = model(op, r, m, p, prev_res);
        @(negedge clk);
        checks++;
        if ({res_wr_o, res_o, psr_o} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d reg=%02h mem=%02h psr=%02h: got wr=%0b res=%02h psr=%02h exp wr=%0b res=%02h psr=%02h",
                     tag, op, r, m, p, res_wr_o, res_o, psr_o, exp[16], exp[15:8], exp[7:0]);
        end
        prev_res = int'(exp[15:8]);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({res_wr_o, res_o, psr_o} !== {1'b0, 8'h00, 8'h36}) begin
            errors++;
            $display("FAIL R1 reset: got wr=%0b res=%02h psr=%02h exp wr=0 res=00 psr=36",
                     res_wr_o, res_o, psr_o);
        end
        rst_n = 1'b1;
        checks++;
        if ({res_wr_o, res_o, psr_o} !== {1'b0, 8'h00, 8'h36}) begin
            errors++;
            $display("FAIL R1 release: got wr=%0b res=%02h psr=%02h exp wr=0 res=00 psr=36",
                     res_wr_o, res_o, psr_o);
        end

        // R2, R3, R4: arithmetic and compare sweeps
        for (int r = 0; r < 256; r++)
            for (int m = 0; m < 256; m += 15)
                for (int c = 0; c < 2; c++) begin
                    run(0,  r, m, ((r * 7 + m) & 8'hFE) | c, "R2");
                    run(1,  r, m, ((r * 5 + m) & 8'hFE) | c, "R3");
                    run(11, r, m, ((r + m * 3) & 8'hFE) | c, "R4");
                end
        // R4: equal operands
        for (int r = 0; r < 256; r++) run(11, r, r, r ^ 8'h41, "R4");

        // R5 logic and R9 bit test
        for (int r = 0; r < 256; r++)
            for (int m = 0; m < 256; m += 15) begin
                run(2, r, m, (r ^ m) & 8'hDF, "R5");
                run(3, r, m, (r + m) & 8'hFF, "R5");
                run(4, r, m, (r * 3) & 8'hFF, "R5");
                run(12, r, m, (m * 3 + r) & 8'hFF, "R9");
            end

        // R6 shifts, R7 inc/dec/transfer/load, R8 stack-pointer transfer
        for (int r = 0; r < 256; r++)
            for (int c = 0; c < 2; c++) begin
                run(5,  r, 0, ((r * 11) & 8'hFE) | c, "R6");
                run(6,  r, 0, ((r * 13) & 8'hFE) | c, "R6");
                run(7,  r, 0, ((r * 17) & 8'hFE) | c, "R6");
                run(8,  r, 0, ((r * 19) & 8'hFE) | c, "R6");
                run(9,  r, 0, ((r * 3) & 8'hFE) | c, "R7");
                run(10, r, 0, ((r * 9) & 8'hFE) | c, "R7");
                run(13, 0, r, ((r * 5) & 8'hFE) | c, "R7");
                run(14, r, 0, ((r * 7) & 8'hFE) | c, "R7");
                run(15, r, 0, ((r * 23) & 8'hFE) | c, "R8");
            end

        // R10 flag operations, result must hold between them
        run(13, 0, 8'hA5, 0, "R10");
        for (int op = 16; op <= 22; op++)
            for (int p = 0; p < 256; p++) run(op, p, 255 - p, p, "R10");

        // R11 constant bit and B/D/I passthrough on a load
        for (int p = 0; p < 256; p++) run(13, 0, p, p, "R11");

        // R12 unassigned opcodes
        for (int op = 23; op < 32; op++)
            for (int p = 0; p < 256; p += 17) run(op, p, p, p, "R12");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule